// File: doc/BRIEF.md
# Masked Multi-CPU Device Interrupt Router

The router gathers level-sensitive device interrupt lines into one shared raw request word. Every CPU owns a full-width mask of its own. Each CPU's hard-interrupt output is high whenever at least one pending raw request is unmasked for that CPU. One bit position, `CASCADE_BIT` (default 55), is reserved for the output of a cascaded legacy interrupt controller. That bit follows the `cascade_irq` pin, and the device line at that position is ignored. Device lines and the cascade pin pass through a two-flop synchronizer and then into the raw register. The raw word therefore reflects the inputs a fixed three clock edges after they are sampled.

Software reaches the block through a one-request, one-response register port carrying 64-bit little-endian words (bit n is line n). A small state machine runs the port. It has two states: `ST_IDLE`, where `req_ready` is high, and `ST_RESP`, where the response is presented. There are two transitions. ACCEPT goes from `ST_IDLE` to `ST_RESP` when `req_valid` is seen. RETIRE goes from `ST_RESP` back to `ST_IDLE` unconditionally on the next edge. A CPU slot can be declared absent through the `CPU_PRESENT` parameter. The output of an absent slot is tied low, but its mask stays readable and writable.

Top module: `irq_router`

## Requirements
- R1: While reset is held, every `cpu_irq` bit and `rsp_valid` are 0 and `req_ready` is 1. After reset, all masks and the raw word read as zero.
- R2: Raw bit n (n ≠ CASCADE_BIT) is 1 exactly when `dev_lines[n]` was high at the clock edge three edges earlier, and 0 otherwise.
- R3: Raw bit CASCADE_BIT (55) follows `cascade_irq` with the same three-edge lag. `dev_lines[55]` has no effect on it.
- R4: CPU masks sit at byte offsets 0x200, 0x240, 0x600 and 0x640 for CPUs 0 to 3. All 64 bits are read/write, and an accepted write takes effect at the accepting edge.
- R5: Per-CPU request views at 0x280, 0x2C0, 0x680 and 0x6C0 (CPUs 0 to 3) return that CPU's mask AND the raw word. Writes to them complete without error and change nothing.
- R6: The raw word reads at 0x300. Writes to it complete without error and change nothing.
- R7: For a present CPU c, `cpu_irq[c]` is 1 exactly when (mask c AND raw) is nonzero. The output updates in the same cycle that a mask write or a raw change lands in its register.
- R8: A CPU whose `CPU_PRESENT` bit is 0 always drives `cpu_irq` low, whatever its mask holds.
- R9: Only accesses with `req_size` = 8 bytes are honoured. Any other size answers with `rsp_err`=1 and `rsp_rdata`=0, and a write of that size changes nothing.
- R10: An access to any offset not listed in R4 to R6 answers with `rsp_err`=1 and `rsp_rdata`=0, and changes nothing.
- R11: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `rsp_valid` is high for exactly the following cycle, and `req_ready` is low during that cycle. Read data is taken from the register state before the accepting edge, and write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_lines | input | NUM_LINES | Level-sensitive device interrupt lines |
| cascade_irq | input | 1 | Cascaded legacy controller output, lands on raw bit CASCADE_BIT |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Port idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | SIZE_W | Access size in bytes (only 8 honoured) |
| req_wdata | input | NUM_LINES | Write data |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Request rejected (bad size or unmapped offset) |
| rsp_rdata | output | NUM_LINES | Read data |
| cpu_irq | output | NUM_CPUS | Per-CPU hard-interrupt request |

## Verification
A change on the device or cascade inputs reaches the raw word, and with it every `cpu_irq`, three edges after the edge that samples it. A mask write changes `cpu_irq` right after the accepting edge. A response shows up in the cycle after acceptance. The bench keeps a reference model that advances on each rising edge: a history queue of the sampled input words, plus the masks and the busy flag. It compares the outputs against that model at every falling edge, so each result is checked in the first cycle it is due and in every cycle after that. Directed reads of the raw word, placed several cycles after a stimulus, pin the latency and the bit-55 substitution explicitly.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    // Register port state machine: IDLE accepts, RESP presents the answer.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } port_state_e;

    // Class of register selected by an address.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_VIEW = 2'd2,
        SEL_RAW  = 2'd3
    } reg_sel_e;

    localparam int ACCESS_BYTES = 8;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
    parameter int NUM_LINES   = 64,
    parameter int CASCADE_BIT = 55,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_lines,
    input  logic                 cascade_irq,
    output logic [NUM_LINES-1:0] raw_q
);
    logic [NUM_LINES-1:0] merged;
    logic [NUM_LINES-1:0] stage_q [SYNC_STAGES];

    // The cascade pin replaces the device line at its reserved position.
    always_comb begin
        merged              = dev_lines;
        merged[CASCADE_BIT] = cascade_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
            raw_q <= '0;
        end else begin
            stage_q[0] <= merged;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            raw_q <= stage_q[SYNC_STAGES-1];
        end
    end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
    parameter int                NUM_CPUS    = 4,
    parameter int                NUM_LINES   = 64,
    parameter logic [NUM_CPUS-1:0] CPU_PRESENT = '1,
    localparam int               CPU_W       = $clog2(NUM_CPUS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [CPU_W-1:0]                    wr_cpu,
    input  logic [NUM_LINES-1:0]                wr_data,
    input  logic [NUM_LINES-1:0]                raw,
    output logic [NUM_CPUS-1:0][NUM_LINES-1:0]  masks,
    output logic [NUM_CPUS-1:0]                 cpu_irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masks <= '0;
        end else if (wr_en) begin
            masks[wr_cpu] <= wr_data;
        end
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        if (CPU_PRESENT[c]) begin : g_live
            assign cpu_irq[c] = |(masks[c] & raw);
        end else begin : g_absent
            assign cpu_irq[c] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12,
    parameter int SIZE_W    = 4,
    localparam int CPU_W    = $clog2(NUM_CPUS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                req_valid,
    input  logic                                req_write,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [SIZE_W-1:0]                   req_size,
    input  logic [NUM_LINES-1:0]                req_wdata,
    input  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  masks,
    input  logic [NUM_LINES-1:0]                raw,
    output logic                                req_ready,
    output logic                                rsp_valid,
    output logic                                rsp_err,
    output logic [NUM_LINES-1:0]                rsp_rdata,
    output logic                                mask_wr_en,
    output logic [CPU_W-1:0]                    mask_wr_cpu,
    output logic [NUM_LINES-1:0]                mask_wr_data
);
    localparam logic [ADDR_W-1:0] MASK_LOW_PAIR  = ADDR_W'(12'h200);
    localparam logic [ADDR_W-1:0] MASK_HIGH_PAIR = ADDR_W'(12'h600);
    localparam logic [ADDR_W-1:0] CPU_STRIDE     = ADDR_W'(12'h040);
    localparam logic [ADDR_W-1:0] VIEW_OFFSET    = ADDR_W'(12'h080);
    localparam logic [ADDR_W-1:0] RAW_ADDR       = ADDR_W'(12'h300);
    localparam logic [SIZE_W-1:0] GOOD_SIZE      = SIZE_W'(ACCESS_BYTES);

    port_state_e          state_q, state_d;
    reg_sel_e             sel;
    logic [CPU_W-1:0]     sel_cpu;
    logic                 bad_access;
    logic                 accept;
    logic [NUM_LINES-1:0] rd_word;
    logic [NUM_LINES-1:0] rdata_q;
    logic                 err_q;

    // CPUs 0/1 sit in the low pair of slots, CPUs 2/3 in the high pair.
    function automatic logic [ADDR_W-1:0] mask_addr(input int c);
        logic [ADDR_W-1:0] base;
        base = (c >= 2) ? MASK_HIGH_PAIR : MASK_LOW_PAIR;
        return base + ((c % 2 == 1) ? CPU_STRIDE : '0);
    endfunction

    always_comb begin
        sel     = SEL_NONE;
        sel_cpu = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            if (req_addr == mask_addr(c)) begin
                sel     = SEL_MASK;
                sel_cpu = CPU_W'(c);
            end
            if (req_addr == mask_addr(c) + VIEW_OFFSET) begin
                sel     = SEL_VIEW;
                sel_cpu = CPU_W'(c);
            end
        end
        if (req_addr == RAW_ADDR) sel = SEL_RAW;
    end

    always_comb begin
        unique case (sel)
            SEL_MASK: rd_word = masks[sel_cpu];
            SEL_VIEW: rd_word = masks[sel_cpu] & raw;
            SEL_RAW:  rd_word = raw;
            default:  rd_word = '0;
        endcase
    end

    assign bad_access   = (req_size != GOOD_SIZE) || (sel == SEL_NONE);
    assign accept       = req_valid && (state_q == ST_IDLE);
    assign mask_wr_en   = accept && req_write && !bad_access && (sel == SEL_MASK);
    assign mask_wr_cpu  = sel_cpu;
    assign mask_wr_data = req_wdata;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT (IDLE->RESP), RETIRE (RESP->IDLE).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            rdata_q <= (bad_access || req_write) ? '0 : rd_word;
            err_q   <= bad_access;
        end
    end

    assign rsp_rdata = rdata_q;
    assign rsp_err   = err_q;
endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int                  NUM_CPUS    = 4,
    parameter int                  NUM_LINES   = 64,
    parameter int                  CASCADE_BIT = 55,
    parameter int                  ADDR_W      = 12,
    parameter int                  SIZE_W      = 4,
    parameter logic [NUM_CPUS-1:0] CPU_PRESENT = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] dev_lines,
    input  logic                 cascade_irq,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic [NUM_LINES-1:0] req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [NUM_LINES-1:0] rsp_rdata,
    output logic [NUM_CPUS-1:0]  cpu_irq
);
    localparam int CPU_W = $clog2(NUM_CPUS);

    logic [NUM_LINES-1:0]               raw_q;
    logic [NUM_CPUS-1:0][NUM_LINES-1:0] masks;
    logic                               mask_wr_en;
    logic [CPU_W-1:0]                   mask_wr_cpu;
    logic [NUM_LINES-1:0]               mask_wr_data;

    irq_line_sync #(
        .NUM_LINES  (NUM_LINES),
        .CASCADE_BIT(CASCADE_BIT),
        .SYNC_STAGES(2)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_lines  (dev_lines),
        .cascade_irq(cascade_irq),
        .raw_q      (raw_q)
    );

    irq_mask_bank #(
        .NUM_CPUS   (NUM_CPUS),
        .NUM_LINES  (NUM_LINES),
        .CPU_PRESENT(CPU_PRESENT)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr_en),
        .wr_cpu (mask_wr_cpu),
        .wr_data(mask_wr_data),
        .raw    (raw_q),
        .masks  (masks),
        .cpu_irq(cpu_irq)
    );

    irq_csr_port #(
        .NUM_CPUS (NUM_CPUS),
        .NUM_LINES(NUM_LINES),
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_wdata   (req_wdata),
        .masks       (masks),
        .raw         (raw_q),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_err     (rsp_err),
        .rsp_rdata   (rsp_rdata),
        .mask_wr_en  (mask_wr_en),
        .mask_wr_cpu (mask_wr_cpu),
        .mask_wr_data(mask_wr_data)
    );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int                  NUM_CPUS    = 4,
    parameter int                  NUM_LINES   = 64,
    parameter int                  CASCADE_BIT = 55,
    parameter logic [NUM_CPUS-1:0] CPU_PRESENT = '1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cascade_irq,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 rsp_valid,
    input logic [NUM_CPUS-1:0]  cpu_irq,
    input logic [NUM_LINES-1:0] raw_q
);
    // Edges seen out of reset, saturating at the three-edge input lag.
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end

    a_r11_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r11_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R3: two synchronizer flops plus the raw register.
    a_r3_cascade_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 2'd3) |-> (raw_q[CASCADE_BIT] == $past(cascade_irq, 3)));

    a_r7_quiet_when_no_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q == '0) |-> (cpu_irq == '0));

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_absent_chk
        if (!CPU_PRESENT[c]) begin : g_off
            a_r8_absent_low: assert property (@(posedge clk) disable iff (!rst_n)
                !cpu_irq[c]);
        end
    end
endmodule

bind irq_router irq_router_chk #(
    .NUM_CPUS   (NUM_CPUS),
    .NUM_LINES  (NUM_LINES),
    .CASCADE_BIT(CASCADE_BIT),
    .CPU_PRESENT(CPU_PRESENT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cascade_irq(cascade_irq),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .cpu_irq    (cpu_irq),
    .raw_q      (raw_q)
);

// File: tb/tb_irq_router.sv
module tb_irq_router;
    localparam int         CLK_PERIOD = 10;
    localparam int         NL = 64;
    localparam int         NC = 4;
    localparam int         CB = 55;
    localparam logic [3:0] PRESENT = 4'b0111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] dev_lines = '0;
    logic          cascade_irq = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [3:0]    req_size = 4'd8;
    logic [NL-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [NL-1:0] rsp_rdata;
    logic [NC-1:0] cpu_irq;

    irq_router #(.CPU_PRESENT(PRESENT)) dut (
        .clk(clk), .rst_n(rst_n), .dev_lines(dev_lines), .cascade_irq(cascade_irq),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cpu_irq(cpu_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [NL-1:0] m_mask [NC];
    logic [NL-1:0] hist [$];
    logic [NL-1:0] m_raw = '0;
    bit            m_busy = 0;
    logic [NL-1:0] m_rdata = '0;
    bit            m_err = 0;
    string         m_tag = "R11";

    function automatic int mask_slot(input logic [11:0] a);
        case (a)
            12'h200: return 0;
            12'h240: return 1;
            12'h600: return 2;
            12'h640: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic int view_slot(input logic [11:0] a);
        case (a)
            12'h280: return 0;
            12'h2C0: return 1;
            12'h680: return 2;
            12'h6C0: return 3;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [NL-1:0] merged;
        int mc, vc;
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) m_mask[c] = '0;
            hist.delete();
            m_raw = '0; m_busy = 0; m_rdata = '0; m_err = 0;
        end else begin
            if (m_busy) begin
                m_busy = 0;
            end else if (req_valid) begin
                m_busy = 1;
                mc = mask_slot(req_addr);
                vc = view_slot(req_addr);
                if (req_size != 4'd8) begin
                    m_err = 1; m_rdata = '0; m_tag = "R9";
                end else if (mc < 0 && vc < 0 && req_addr != 12'h300) begin
                    m_err = 1; m_rdata = '0; m_tag = "R10";
                end else begin
                    m_err = 0;
                    if (mc >= 0) m_tag = "R4";
                    else if (vc >= 0) m_tag = "R5";
                    else m_tag = "R6";
                    if (req_write) begin
                        m_rdata = '0;
                        if (mc >= 0) m_mask[mc] = req_wdata;
                    end else if (mc >= 0) m_rdata = m_mask[mc];
                    else if (vc >= 0)     m_rdata = m_mask[vc] & m_raw;
                    else                  m_rdata = m_raw;
                end
            end
            merged = dev_lines;
            merged[CB] = cascade_irq;
            hist.push_front(merged);
            if (hist.size() > 3) void'(hist.pop_back());
            m_raw = (hist.size() >= 3) ? hist[2] : '0;
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(req_ready == !m_busy, "R11 ready", NL'(req_ready), NL'(!m_busy));
            chk(rsp_valid == m_busy, "R11 rsp_valid", NL'(rsp_valid), NL'(m_busy));
            if (m_busy) begin
                chk(rsp_err == m_err, {m_tag, " err"}, NL'(rsp_err), NL'(m_err));
                chk(rsp_rdata == m_rdata, {m_tag, " rdata"}, rsp_rdata, m_rdata);
            end
            for (int c = 0; c < NC; c++) begin
                logic e;
                e = PRESENT[c] && (|(m_mask[c] & m_raw));
                chk(cpu_irq[c] == e, (c == 3) ? "R8 absent irq" : "R7 irq", NL'(cpu_irq[c]), NL'(e));
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit wr, input logic [11:0] a, input logic [3:0] sz,
                          input logic [NL-1:0] wd, output logic [NL-1:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        @(negedge clk);
        rd = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [NL-1:0] rd;
    logic [NL-1:0] pat;
    logic [11:0] addr_list [14] = '{12'h200, 12'h240, 12'h600, 12'h640,
                                    12'h280, 12'h2C0, 12'h680, 12'h6C0,
                                    12'h300, 12'h208, 12'h340, 12'h700,
                                    12'hC00, 12'h000};

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(cpu_irq == '0, "R1 irq in reset", NL'(cpu_irq), '0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", NL'(rsp_valid), '0);
        chk(req_ready == 1'b1, "R1 ready in reset", NL'(req_ready), NL'(1));
        rst_n = 1'b1;
        access(0, 12'h200, 4'd8, '0, rd);
        chk(rd == '0, "R1 mask0 after reset", rd, '0);
        access(0, 12'h300, 4'd8, '0, rd);
        chk(rd == '0, "R1 raw after reset", rd, '0);

        // R2: raw follows lines three edges later
        pat = 64'hA5A5_0000_F00F_1234;
        dev_lines = pat;
        idle(4);
        access(0, 12'h300, 4'd8, '0, rd);
        chk(rd == (pat & ~(64'd1 << CB)), "R2 raw pattern", rd, pat & ~(64'd1 << CB));
        dev_lines = '0;
        idle(4);
        access(0, 12'h300, 4'd8, '0, rd);
        chk(rd == '0, "R2 raw clears", rd, '0);

        // R3: cascade owns bit 55, device line 55 ignored
        dev_lines = 64'd1 << CB;
        idle(4);
        access(0, 12'h300, 4'd8, '0, rd);
        chk(rd == '0, "R3 dev line 55 ignored", rd, '0);
        cascade_irq = 1'b1;
        dev_lines = '0;
        idle(4);
        access(0, 12'h300, 4'd8, '0, rd);
        chk(rd == (64'd1 << CB), "R3 cascade bit", rd, 64'd1 << CB);
        cascade_irq = 1'b0;

        // R4 / R7 / R8: masks, outputs, absent slot
        access(1, 12'h200, 4'd8, 64'h0000_0000_0000_00FF, rd);
        access(1, 12'h240, 4'd8, 64'hFF00_0000_0000_0000, rd);
        access(1, 12'h600, 4'd8, 64'h0080_0000_0000_0000, rd);
        access(1, 12'h640, 4'd8, '1, rd);
        access(0, 12'h640, 4'd8, '0, rd);
        chk(rd == '1, "R4 mask3 readback", rd, '1);
        dev_lines = 64'h0000_0000_0000_0010;
        idle(5);
        chk(cpu_irq == 4'b0001, "R7 only cpu0", NL'(cpu_irq), NL'(4'b0001));
        cascade_irq = 1'b1;
        idle(5);
        chk(cpu_irq == 4'b0101, "R7 cascade to cpu2, R8 cpu3 low", NL'(cpu_irq), NL'(4'b0101));
        access(0, 12'h680, 4'd8, '0, rd);
        chk(rd == (64'd1 << CB), "R5 view cpu2", rd, 64'd1 << CB);

        // R5 / R6: writes to views and raw change nothing
        access(1, 12'h280, 4'd8, '1, rd);
        access(1, 12'h300, 4'd8, '0, rd);
        access(0, 12'h200, 4'd8, '0, rd);
        chk(rd == 64'hFF, "R5 view write ignored", rd, 64'hFF);

        // R9: wrong size rejected, no effect
        access(1, 12'h200, 4'd4, '0, rd);
        access(0, 12'h200, 4'd8, '0, rd);
        chk(rd == 64'hFF, "R9 short write ignored", rd, 64'hFF);

        // R10: unmapped offset
        access(1, 12'h208, 4'd8, '0, rd);
        access(0, 12'h700, 4'd8, '0, rd);
        chk(rd == '0, "R10 unmapped read", rd, '0);

        // Random mix, checked every cycle by the model
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            a = addr_list[$urandom_range(0, 13)];
            dev_lines = {$urandom, $urandom} & {$urandom, $urandom};
            cascade_irq = $urandom_range(0, 1);
            access($urandom_range(0, 1), a, ($urandom_range(0, 7) == 0) ? 4'd2 : 4'd8,
                   {$urandom, $urandom} & {$urandom, $urandom}, rd);
            idle($urandom_range(0, 3));
        end

        idle(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule